// File: doc/BRIEF.md
# Paged Translation Permission Checker

This block takes one translation entry that a lookup stage has already matched. The entry holds two halves, one for an even page and one for an odd page. The block also takes the virtual address, the access kind, the current privilege level and a flag that selects 32-bit or 64-bit operation. It picks the half that covers the address and checks the access rights in a fixed priority order. It returns a 3-bit result code, the physical address and a read/write/execute permission vector.

The page size is variable. For an entry in the fully associative region it comes from the entry itself. For an entry in the set-associative region it comes from one shared size value. Each half also selects its own privilege rule: either the current level must be at most the page level, or it must equal the page level exactly.

The checking logic is combinational. Its results are captured in a register stage on a request strobe. They appear one cycle later, together with a response-valid flag.

Top module: `tlb_perm_check`

## Requirements
- R1: The page size PS is `entryPs` when `fullAssoc` is 1 and `globalPs` when `fullAssoc` is 0. Address bit `vaddr[PS]` selects the half: 0 selects `evenHalf` and 1 selects `oddHalf`.
- R2: A PS value below 12 or above 30 gives result code 3, no matter what the entry holds.
- R3: Each half is packed as follows: bit 0 valid, bit 1 dirty, bits 3:2 page privilege, bit 4 no-execute, bit 5 no-read, bit 6 restrict-privilege, and bits from 7 upward the physical page number. The access kinds are 0 fetch, 1 load and 2 store; the value 3 is checked as a load. Checks run in this order and the first failure decides the code: valid clear gives 3; a fetch with no-execute gives 6; a load with no-read gives 5; a privilege error gives 7; a store with dirty clear gives 4. If every check passes, the code is 0.
- R4: When restrict-privilege is 0, a privilege error occurs if `curPriv` is numerically greater than the page privilege. When restrict-privilege is 1, a privilege error occurs if `curPriv` differs from the page privilege.
- R5: When `wide64` is 0, the no-execute, no-read and restrict-privilege bits are treated as 0.
- R6: On code 0 the physical address is formed from two parts. Below bit PS it takes the virtual address bits. From bit PS upward it takes the page number shifted left by 12. Page-number bits that would land below bit PS are discarded.
- R7: On code 0 the permission vector `{read, write, exec}` is `{1, dirty, !noExec}`, using the effective no-execute bit from R5. On any other code both `permRwx` and `physAddr` are 0.
- R8: Code, address and permissions appear on the clock edge after a cycle with `reqValid` high, and `respValid` is 1 in that cycle. After a cycle without a request, `respValid` is 0 and the other outputs keep their values.
- R9: During reset and right after it, `respValid`, `resultCode`, `physAddr` and `permRwx` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request strobe |
| vaddr | input | VA_W | Virtual address |
| accessKind | input | 2 | 0 fetch, 1 load, 2 store, 3 load |
| curPriv | input | PRIV_W | Current privilege level |
| wide64 | input | 1 | 1 selects 64-bit operation |
| fullAssoc | input | 1 | Entry belongs to the fully associative region |
| entryPs | input | 6 | Page size from the entry |
| globalPs | input | 6 | Shared page size for the set-associative region |
| evenHalf | input | HALF_W | Even page half |
| oddHalf | input | HALF_W | Odd page half |
| respValid | output | 1 | Response valid |
| resultCode | output | 3 | Check result code |
| physAddr | output | PA_W | Physical address |
| permRwx | output | 3 | Read, write and execute permissions |

## Verification
The bench runs random entries against a reference model and adds directed cases for these corner cases:
- **Page-size limits.** PS of 12 and 30 must translate. PS of 11 and 31 must be rejected. A design that gets these limits wrong translates illegal sizes or refuses legal ones.
- **Software bits.** A page-number bit set just below PS must be discarded. If it is not cleared, it leaks into the physical address.
- **Priority when several faults overlap.** An invalid half that also has no-execute set must report invalid. A privilege fault must win over a dirty fault. A design with the checks in the wrong order returns the later code.
- **Exact privilege rule.** A lower current level against a restricted page must fault. A design that applies the at-most rule here lets the access through.
- **32-bit mode.** The mode must mask the inhibit bits. Otherwise fetches and loads fault in that mode.
- **Hold after a request.** Inputs that change without a request must leave the outputs alone. Otherwise the outputs follow the inputs.

// File: rtl/tlb_perm_pkg.sv
package tlb_perm_pkg;

  typedef enum logic [1:0] {
    ACC_FETCH = 2'd0,
    ACC_LOAD  = 2'd1,
    ACC_STORE = 2'd2,
    ACC_LOAD2 = 2'd3
  } accessKindE;

  typedef enum logic [2:0] {
    RES_OK       = 3'd0,
    RES_INVALID  = 3'd3,
    RES_DIRTY    = 3'd4,
    RES_NOREAD   = 3'd5,
    RES_NOEXEC   = 3'd6,
    RES_PRIVFAIL = 3'd7
  } resultCodeE;

  // strobes from control to datapath
  typedef struct packed {
    logic capture;
  } ctlStrobesT;

  // half-entry bit positions
  localparam int HB_VALID    = 0;
  localparam int HB_DIRTY    = 1;
  localparam int HB_PRIV_LO  = 2;
  localparam int HB_NOEXEC   = 4;
  localparam int HB_NOREAD   = 5;
  localparam int HB_RESTRICT = 6;
  localparam int HB_PPN_LO   = 7;

  localparam int PAGE_SHIFT  = 12;
  localparam int PS_MIN      = 12;
  localparam int PS_MAX      = 30;

endpackage

// File: rtl/tlb_perm_ctl.sv
module tlb_perm_ctl
  import tlb_perm_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  output ctlStrobesT strobes,
  output logic       respValid
);

  always_comb begin
    strobes.capture = reqValid;
  end

  always_ff @(posedge clk) begin
    if (!rstN) respValid <= 1'b0;
    else       respValid <= reqValid;
  end

  // R8
  resp_follows_req_chk: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> respValid);

  // R8
  resp_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> !respValid);

endmodule

// File: rtl/tlb_perm_dp.sv
module tlb_perm_dp
  import tlb_perm_pkg::*;
#(
  parameter int VA_W   = 48,
  parameter int PA_W   = 48,
  parameter int PRIV_W = 2,
  parameter int PPN_W  = PA_W - PAGE_SHIFT,
  parameter int HALF_W = HB_PPN_LO + PPN_W
)(
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobesT        strobes,
  input  logic [VA_W-1:0]   vaddr,
  input  logic [1:0]        accessKind,
  input  logic [PRIV_W-1:0] curPriv,
  input  logic              wide64,
  input  logic              fullAssoc,
  input  logic [5:0]        entryPs,
  input  logic [5:0]        globalPs,
  input  logic [HALF_W-1:0] evenHalf,
  input  logic [HALF_W-1:0] oddHalf,
  output logic [2:0]        resultCode,
  output logic [PA_W-1:0]   physAddr,
  output logic [2:0]        permRwx
);

  localparam int PRIV_HI = HB_PRIV_LO + PRIV_W - 1;

  logic [5:0]        psSel;
  logic              psOk;
  logic              oddSel;
  logic [HALF_W-1:0] half;
  logic              hValid, hDirty, hNoExec, hNoRead, hRestrict;
  logic [PRIV_W-1:0] hPriv;
  logic [PPN_W-1:0]  hPpn;
  logic              isFetch, isLoad, isStore;
  logic              privErr;
  resultCodeE        codeNext;
  logic [PA_W-1:0]   paRaw;
  logic [PA_W-1:0]   paNext;
  logic [2:0]        permNext;

  // page size and half selection
  always_comb begin
    psSel  = fullAssoc ? entryPs : globalPs;
    psOk   = (psSel >= 6'(PS_MIN)) && (psSel <= 6'(PS_MAX));
    oddSel = 1'b0;
    for (int b = PS_MIN; b <= PS_MAX; b++) begin
      if (psSel == 6'(b)) oddSel = vaddr[b];
    end
    half = oddSel ? oddHalf : evenHalf;
  end

  // field decode with 32-bit masking
  always_comb begin
    hValid    = half[HB_VALID];
    hDirty    = half[HB_DIRTY];
    hPriv     = half[PRIV_HI:HB_PRIV_LO];
    hNoExec   = wide64 & half[HB_NOEXEC];
    hNoRead   = wide64 & half[HB_NOREAD];
    hRestrict = wide64 & half[HB_RESTRICT];
    hPpn      = half[HALF_W-1:HB_PPN_LO];
  end

  // access classification
  always_comb begin
    isFetch = (accessKind == ACC_FETCH);
    isStore = (accessKind == ACC_STORE);
    isLoad  = (accessKind == ACC_LOAD) || (accessKind == ACC_LOAD2);
  end

  // privilege rule
  always_comb begin
    if (hRestrict) privErr = (curPriv != hPriv);
    else           privErr = (curPriv > hPriv);
  end

  // prioritized check
  always_comb begin
    if (!psOk || !hValid)        codeNext = RES_INVALID;
    else if (isFetch && hNoExec) codeNext = RES_NOEXEC;
    else if (isLoad && hNoRead)  codeNext = RES_NOREAD;
    else if (privErr)            codeNext = RES_PRIVFAIL;
    else if (isStore && !hDirty) codeNext = RES_DIRTY;
    else                         codeNext = RES_OK;
  end

  // address formation: offset bits below PS, page bits at and above PS
  always_comb begin
    paRaw = '0;
    for (int b = 0; b < PA_W; b++) begin
      if (b < int'(psSel) && b < VA_W) paRaw[b] = vaddr[b];
      else if (b >= PAGE_SHIFT)        paRaw[b] = hPpn[b-PAGE_SHIFT];
    end
  end

  always_comb begin
    if (codeNext == RES_OK) begin
      paNext   = paRaw;
      permNext = {1'b1, hDirty, ~hNoExec};
    end else begin
      paNext   = '0;
      permNext = 3'b000;
    end
  end

  // registered output stage
  always_ff @(posedge clk) begin
    if (!rstN) begin
      resultCode <= 3'd0;
      physAddr   <= '0;
      permRwx    <= 3'b000;
    end else if (strobes.capture) begin
      resultCode <= codeNext;
      physAddr   <= paNext;
      permRwx    <= permNext;
    end
  end

  // R2
  bad_ps_invalid_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.capture && !psOk) |=> (resultCode == 3'd3));

  // R3
  noexec_only_fetch_chk: assert property (@(posedge clk) disable iff (!rstN)
    (codeNext == RES_NOEXEC) |-> (isFetch && wide64));

  // R5
  narrow_no_inhibit_chk: assert property (@(posedge clk) disable iff (!rstN)
    !wide64 |-> (codeNext != RES_NOEXEC && codeNext != RES_NOREAD));

  // R7
  ok_grants_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    (resultCode == 3'd0 && permRwx != 3'b000) |-> permRwx[2]);

  // R7
  fail_zero_out_chk: assert property (@(posedge clk) disable iff (!rstN)
    (resultCode != 3'd0) |-> (permRwx == 3'b000 && physAddr == '0));

  // R8
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.capture |=> ($stable(resultCode) && $stable(physAddr) && $stable(permRwx)));

endmodule

// File: rtl/tlb_perm_check.sv
module tlb_perm_check
  import tlb_perm_pkg::*;
#(
  parameter int VA_W   = 48,
  parameter int PA_W   = 48,
  parameter int PRIV_W = 2,
  parameter int HALF_W = HB_PPN_LO + PA_W - PAGE_SHIFT
)(
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [VA_W-1:0]   vaddr,
  input  logic [1:0]        accessKind,
  input  logic [PRIV_W-1:0] curPriv,
  input  logic              wide64,
  input  logic              fullAssoc,
  input  logic [5:0]        entryPs,
  input  logic [5:0]        globalPs,
  input  logic [HALF_W-1:0] evenHalf,
  input  logic [HALF_W-1:0] oddHalf,
  output logic              respValid,
  output logic [2:0]        resultCode,
  output logic [PA_W-1:0]   physAddr,
  output logic [2:0]        permRwx
);

  localparam int PPN_W = PA_W - PAGE_SHIFT;

  ctlStrobesT strobes;

  tlb_perm_ctl u_ctl (
    .clk       (clk),
    .rstN      (rstN),
    .reqValid  (reqValid),
    .strobes   (strobes),
    .respValid (respValid)
  );

  tlb_perm_dp #(
    .VA_W   (VA_W),
    .PA_W   (PA_W),
    .PRIV_W (PRIV_W),
    .PPN_W  (PPN_W),
    .HALF_W (HALF_W)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .vaddr      (vaddr),
    .accessKind (accessKind),
    .curPriv    (curPriv),
    .wide64     (wide64),
    .fullAssoc  (fullAssoc),
    .entryPs    (entryPs),
    .globalPs   (globalPs),
    .evenHalf   (evenHalf),
    .oddHalf    (oddHalf),
    .resultCode (resultCode),
    .physAddr   (physAddr),
    .permRwx    (permRwx)
  );

endmodule

// File: tb/tb_tlb_perm_check.sv
module tb_tlb_perm_check;

  localparam int VA_W = 48;
  localparam int PA_W = 48;
  localparam int HW   = 7 + PA_W - 12;

  logic            clk = 1'b0;
  logic            rstN = 1'b0;
  logic            reqValid = 1'b0;
  logic [VA_W-1:0] vaddr = '0;
  logic [1:0]      accessKind = 2'd0;
  logic [1:0]      curPriv = 2'd0;
  logic            wide64 = 1'b1;
  logic            fullAssoc = 1'b0;
  logic [5:0]      entryPs = 6'd12;
  logic [5:0]      globalPs = 6'd12;
  logic [HW-1:0]   evenHalf = '0;
  logic [HW-1:0]   oddHalf = '0;
  logic            respValid;
  logic [2:0]      resultCode;
  logic [PA_W-1:0] physAddr;
  logic [2:0]      permRwx;

  int testCount = 0;
  int failCount = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  tlb_perm_check dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .vaddr(vaddr),
    .accessKind(accessKind), .curPriv(curPriv), .wide64(wide64),
    .fullAssoc(fullAssoc), .entryPs(entryPs), .globalPs(globalPs),
    .evenHalf(evenHalf), .oddHalf(oddHalf), .respValid(respValid),
    .resultCode(resultCode), .physAddr(physAddr), .permRwx(permRwx)
  );

  function automatic logic [HW-1:0] mkHalf(logic v, logic d, logic [1:0] pl,
      logic nx, logic nr, logic rp, logic [PA_W-13:0] ppn);
    return {ppn, rp, nr, nx, pl, d, v};
  endfunction

  task automatic refModel(output logic [2:0] code, output logic [PA_W-1:0] pa,
                          output logic [2:0] perm);
    int ps;
    logic [HW-1:0] h;
    logic nx, nr, rp, pe;
    logic [63:0] ppn64, pa64;
    ps = fullAssoc ? int'(entryPs) : int'(globalPs);
    code = 3'd0; pa = '0; perm = 3'b000;
    if (ps < 12 || ps > 30) begin
      code = 3'd3;
      return;
    end
    h  = vaddr[ps] ? oddHalf : evenHalf;
    nx = wide64 & h[4];
    nr = wide64 & h[5];
    rp = wide64 & h[6];
    pe = rp ? (curPriv != h[3:2]) : (curPriv > h[3:2]);
    if (!h[0])                                            code = 3'd3;
    else if (accessKind == 2'd0 && nx)                    code = 3'd6;
    else if ((accessKind == 2'd1 || accessKind == 2'd3) && nr) code = 3'd5;
    else if (pe)                                          code = 3'd7;
    else if (accessKind == 2'd2 && !h[1])                 code = 3'd4;
    if (code == 3'd0) begin
      ppn64 = 64'(h[HW-1:7]);
      ppn64 = ppn64 & ~((64'd1 << (ps - 12)) - 64'd1);
      pa64  = (ppn64 << 12) | (64'(vaddr) & ((64'd1 << ps) - 64'd1));
      pa    = pa64[PA_W-1:0];
      perm  = {1'b1, h[1], ~nx};
    end
  endtask

  task automatic checkOut(string tag, logic [2:0] eCode, logic [PA_W-1:0] ePa,
                          logic [2:0] ePerm, logic eResp);
    testCount++;
    if (resultCode !== eCode || physAddr !== ePa || permRwx !== ePerm ||
        respValid !== eResp) begin
      failCount++;
      $display("FAIL %s: got code=%0d pa=%h perm=%b resp=%b, expected code=%0d pa=%h perm=%b resp=%b",
               tag, resultCode, physAddr, permRwx, respValid, eCode, ePa, ePerm, eResp);
    end
  endtask

  // drive at negedge with reqValid high, sample at next negedge
  task automatic runReq(string tag);
    logic [2:0] c; logic [PA_W-1:0] p; logic [2:0] m;
    refModel(c, p, m);
    reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
    checkOut(tag, c, p, m, 1'b1);
  endtask

  task automatic setBase();
    wide64 = 1'b1; fullAssoc = 1'b0; globalPs = 6'd12; entryPs = 6'd12;
    accessKind = 2'd1; curPriv = 2'd0; vaddr = '0;
    evenHalf = mkHalf(1, 1, 2'd3, 0, 0, 0, 36'h0_1234_5678);
    oddHalf  = mkHalf(1, 1, 2'd3, 0, 0, 0, 36'h0_8765_4321);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!finished) begin
      failCount++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("[TB] %0d tests run, %0d failed", testCount, failCount);
      $finish;
    end
  end

  initial begin : stim
    logic [2:0] hc; logic [PA_W-1:0] hp; logic [2:0] hm;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    // R9 reset state
    checkOut("R9 reset", 3'd0, '0, 3'b000, 1'b0);
    rstN = 1'b1;
    @(negedge clk);
    checkOut("R9 after reset", 3'd0, '0, 3'b000, 1'b0);

    // R1 even/odd selection and PS source
    setBase(); @(negedge clk);
    vaddr = 48'h0000_0000_0abc; runReq("R1 even half");
    vaddr = 48'h0000_0000_1abc; runReq("R1 odd half");
    fullAssoc = 1'b1; entryPs = 6'd14; vaddr = 48'h0000_0000_4123; runReq("R1 entry ps odd");
    entryPs = 6'd13; vaddr = 48'h0000_0000_4123; runReq("R1 entry ps even");
    fullAssoc = 1'b0;

    // R2 page-size range
    globalPs = 6'd11; runReq("R2 ps 11");
    globalPs = 6'd31; runReq("R2 ps 31");
    globalPs = 6'd30; vaddr = 48'h0000_7fff_ffff; runReq("R2 ps 30 ok");
    globalPs = 6'd12;

    // R6 software bits cleared
    globalPs = 6'd16; vaddr = 48'h0000_0000_fedc;
    evenHalf = mkHalf(1, 1, 2'd3, 0, 0, 0, 36'h0_0000_001f);
    runReq("R6 soft bits");

    // R3 priority: invalid over noexec
    setBase(); accessKind = 2'd0;
    evenHalf = mkHalf(0, 1, 2'd3, 1, 1, 0, 36'h1);
    runReq("R3 invalid first");
    evenHalf = mkHalf(1, 0, 2'd0, 0, 1, 0, 36'h1); curPriv = 2'd3; accessKind = 2'd2;
    runReq("R3 priv over dirty");
    curPriv = 2'd0; runReq("R3 dirty code");
    accessKind = 2'd3; runReq("R3 kind3 noread");

    // R4 exact privilege
    evenHalf = mkHalf(1, 1, 2'd2, 0, 0, 1, 36'h5); accessKind = 2'd1; curPriv = 2'd1;
    runReq("R4 restrict lower");
    curPriv = 2'd2; runReq("R4 restrict equal");
    evenHalf = mkHalf(1, 1, 2'd2, 0, 0, 0, 36'h5); curPriv = 2'd1;
    runReq("R4 at-most lower");

    // R5 32-bit mode masks inhibit bits
    wide64 = 1'b0; evenHalf = mkHalf(1, 0, 2'd2, 1, 1, 1, 36'h9);
    accessKind = 2'd0; curPriv = 2'd0; runReq("R5 narrow fetch");
    accessKind = 2'd1; runReq("R5 narrow load");
    wide64 = 1'b1; accessKind = 2'd0; runReq("R7 noexec wide");

    // R8 hold without request
    setBase(); runReq("R8 setup");
    refModel(hc, hp, hm);
    vaddr = 48'h0000_0000_1fff; oddHalf = mkHalf(0, 0, 0, 0, 0, 0, 36'h0);
    @(negedge clk);
    checkOut("R8 hold", hc, hp, hm, 1'b0);

    // random mix (R3 R6 R7)
    for (int i = 0; i < 600; i++) begin
      vaddr      = {$urandom(), $urandom()} & 48'h7fff_ffff_ffff;
      accessKind = 2'($urandom());
      curPriv    = 2'($urandom());
      wide64     = 1'($urandom());
      fullAssoc  = 1'($urandom());
      entryPs    = ($urandom_range(0, 9) == 0) ? 6'($urandom()) : 6'($urandom_range(12, 30));
      globalPs   = ($urandom_range(0, 9) == 0) ? 6'($urandom()) : 6'($urandom_range(12, 30));
      evenHalf   = HW'({$urandom(), $urandom()}) | HW'(($urandom_range(0, 3) != 0) ? 1 : 0);
      oddHalf    = HW'({$urandom(), $urandom()}) | HW'(($urandom_range(0, 3) != 0) ? 1 : 0);
      runReq("R3 R6 R7 random");
    end

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end

endmodule